// File: doc/BRIEF.md
# Frame Sequencer with Length Counters and Envelopes

This block is the slow timing heart of a multi-channel sound unit. A fractional divider turns the CPU clock into a step clock of roughly 240 Hz. The step clock walks a four-step or a five-step sequence. From the sequence it derives quarter-frame strobes, which clock a volume envelope in every channel, and half-frame strobes, which count down a per-channel length counter. In four-step mode each completed sequence can also raise a periodic interrupt.

Software drives the block through one byte-wide write port. The writes select the per-channel envelope rate and halt/loop bit, the length reload index, the channel enables and the sequence mode. A read strobe samples a status byte and acknowledges both pending interrupts. The waveform generators and the mixer sit outside and use the length-active flags and envelope volumes that the block exports.

Top module: `frame_sequencer`

## Requirements
- R1: After reset all length counters, envelope volumes, enables, interrupt flags, the step and the accumulator are zero, so `lenActive`, `envVol`, `irq` and `rdData` (with `sampleBusy` low) read zero.
- R2: Each cycle the accumulator grows by DIV_INC. When the sum reaches DIV_LIMIT, DIV_LIMIT is subtracted and the step advances, so the first step occurs on the ceil(k*DIV_LIMIT/DIV_INC)-th cycle after a frame write. The defaults 2 and 14915 give one step per 7457.5 cycles on average.
- R3: Address 9 is the frame register. Bit 7 set selects five steps (0..4) and clear selects four steps (0..3). Writing it zeroes the accumulator and the step, and it takes priority over a step due in the same cycle.
- R4: In four-step mode with the inhibit bit (bit 6 of address 9) clear, every wrap of the step to 0 sets the frame interrupt flag. Five-step mode never sets it.
- R5: A quarter-frame strobe fires when the new step is below 4. A half-frame strobe fires when the new step ANDed with 5 equals 1, that is on new steps 1 and 3.
- R6: A write to address 4+n loads channel n's length counter from a table indexed by data bits 7:3, but only when channel n is enabled. Index 1 gives 254. Any other odd index i gives i-1. Even index 2k gives 10,20,40,80,160,60,14,26 for k = 0..7, and 12,24,48,96,192,72,16,32 for k = 8..15.
- R7: On each half-frame strobe a non-zero length counter decrements by one, unless the halt bit of that channel (bit 5 at address n) is set. A counter at zero stays at zero.
- R8: A length write sets the channel's volume to 15 and its divider to the rate (bits 3:0 at address n), whether or not the channel is enabled. On a quarter-frame strobe a zero divider reloads the rate and steps the volume; otherwise the divider counts down. A volume step decrements a non-zero volume. It wraps 0 to 15 only when the loop bit (the same bit 5) is set.
- R9: Address 8 holds the channel enables in bits 3:0. A cleared enable forces the length counter to zero and holds it there.
- R10: `rdData` shows length-active flags in bits 3:0, `sampleBusy` in bit 4, zero in bit 5, the frame flag in bit 6 and the sample flag in bit 7. A cycle with `rdStb` high clears both flags at the next edge, unless a flag is set in that same cycle.
- R11: A pulse on `sampleIrqSet` sets the sample flag. A frame write with bit 6 set clears both flags.
- R12: `irq` is high exactly when the frame flag or the sample flag is pending.
- R13: Writes to addresses 10 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| rdStb | input | 1 | Status read strobe, acknowledges interrupts |
| sampleBusy | input | 1 | Sample channel activity, reported in status bit 4 |
| sampleIrqSet | input | 1 | Sets the sample interrupt flag |
| rdData | output | 8 | Status byte |
| lenActive | output | 4 | Per-channel length counter non-zero |
| envVol | output | 16 | Per-channel envelope volume, channel n in bits 4n+3:4n |
| irq | output | 1 | Interrupt request |

## Verification
The bench loads eight table entries and times the exact half-frame at which each counter empties. A wrong table entry, a wrong half-frame decode or a divider that loses its fractional remainder moves that edge by whole steps. Envelope tests cover a divider of 1, a looping volume that wraps at the sixteenth quarter-frame, and a non-looping volume that sticks at zero. In five-step mode step 4 must pass without an envelope step and without an interrupt. The frame interrupt is checked one cycle before and on the cycle of the fourth step. The checks then cover its clearing by a read and by the inhibit bit, length loads into disabled channels, the halt bit, and writes to unused addresses.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int ADDR_W         = 4;
  localparam int VOL_W          = 4;
  localparam int LEN_W          = 8;
  localparam int IDX_W          = 5;
  localparam int ADDR_CTRL_BASE = 0;
  localparam int ADDR_LEN_BASE  = 4;
  localparam int ADDR_ENABLE    = 8;
  localparam int ADDR_FRAME     = 9;

  // Strobes from the sequencer control to the channel datapath
  typedef struct packed {
    logic quarter;
    logic half;
  } seqTick_t;

  // Length reload value for a 5-bit index
  function automatic logic [LEN_W-1:0] lenLookup(input logic [IDX_W-1:0] idx);
    logic [LEN_W-1:0] val;
    if (idx[0]) begin
      val = (idx == 5'd1) ? 8'd254 : ({3'b000, idx} - 8'd1);
    end else begin
      case (idx[3:1])
        3'd5:    val = idx[4] ? 8'd72 : 8'd60;
        3'd6:    val = idx[4] ? 8'd16 : 8'd14;
        3'd7:    val = idx[4] ? 8'd32 : 8'd26;
        default: val = (idx[4] ? 8'd12 : 8'd10) << idx[3:1];
      endcase
    end
    return val;
  endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int DIV_INC   = 2,
  parameter int DIV_LIMIT = 14915
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameWr,
  input  logic     modeIn,
  input  logic     inhibitIn,
  input  logic     rdStb,
  input  logic     sampleIrqSet,
  output seqTick_t tick,
  output logic     frameFlag,
  output logic     sampleFlag
);

  localparam int ACC_W = $clog2(DIV_LIMIT + DIV_INC + 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic             stepTick;
  logic             advance;
  logic [2:0]       stepCnt;
  logic [2:0]       lastStep;
  logic [2:0]       nextStep;
  logic             mode5;
  logic             inhibit;
  logic             frameSet;

  // Fractional divider
  always_comb begin
    accSum   = acc + ACC_W'(DIV_INC);
    stepTick = (accSum >= ACC_W'(DIV_LIMIT));
    advance  = stepTick && !frameWr;
  end

  // Sequence position
  always_comb begin
    lastStep = mode5 ? 3'd4 : 3'd3;
    nextStep = (stepCnt >= lastStep) ? 3'd0 : stepCnt + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      stepCnt <= '0;
      mode5   <= 1'b0;
      inhibit <= 1'b0;
    end else if (frameWr) begin
      acc     <= '0;
      stepCnt <= '0;
      mode5   <= modeIn;
      inhibit <= inhibitIn;
    end else if (stepTick) begin
      acc     <= accSum - ACC_W'(DIV_LIMIT);
      stepCnt <= nextStep;
    end else begin
      acc     <= accSum;
    end
  end

  // Strobe decode
  always_comb begin
    tick.quarter = advance && (nextStep < 3'd4);
    tick.half    = advance && ((nextStep & 3'd5) == 3'd1);
    frameSet     = advance && (nextStep == 3'd0) && !mode5 && !inhibit;
  end

  // Pending interrupt flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameFlag <= 1'b0;
    end else if (frameSet) begin
      frameFlag <= 1'b1;
    end else if (rdStb || (frameWr && inhibitIn)) begin
      frameFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleFlag <= 1'b0;
    end else if (sampleIrqSet) begin
      sampleFlag <= 1'b1;
    end else if (rdStb || (frameWr && inhibitIn)) begin
      sampleFlag <= 1'b0;
    end
  end

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc < ACC_W'(DIV_LIMIT));

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepCnt <= 3'd4) && (mode5 || stepCnt < 3'd4));

  // R4
  frame_flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameFlag) |-> (!mode5 && !inhibit && stepCnt == 3'd0));

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !sampleIrqSet) |=> !sampleFlag);

endmodule

// File: rtl/fseq_chan.sv
module fseq_chan
  import fseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqTick_t         tick,
  input  logic             enabled,
  input  logic             ctrlWr,
  input  logic             haltIn,
  input  logic [3:0]       rateIn,
  input  logic             lenWr,
  input  logic [IDX_W-1:0] lenIdx,
  output logic             lenNz,
  output logic [VOL_W-1:0] vol
);

  logic             haltLoop;
  logic [3:0]       rate;
  logic [3:0]       divCnt;
  logic [LEN_W-1:0] lenCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltLoop <= 1'b0;
      rate     <= '0;
    end else if (ctrlWr) begin
      haltLoop <= haltIn;
      rate     <= rateIn;
    end
  end

  // Length counter
  always_ff @(posedge clk) begin
    if (!rstN || !enabled) begin
      lenCnt <= '0;
    end else if (lenWr) begin
      lenCnt <= lenLookup(lenIdx);
    end else if (tick.half && lenCnt != '0 && !haltLoop) begin
      lenCnt <= lenCnt - 1'b1;
    end
  end

  // Envelope divider and volume
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      vol    <= '0;
    end else if (lenWr) begin
      divCnt <= rate;
      vol    <= '1;
    end else if (tick.quarter) begin
      if (divCnt == '0) begin
        divCnt <= rate;
        if (vol != '0 || haltLoop) vol <= vol - 1'b1;
      end else begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end

  assign lenNz = (lenCnt != '0);

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enabled) && $past(haltLoop) && !$past(lenWr)) |-> (lenCnt == $past(lenCnt)));

  // R7
  len_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enabled) && !$past(lenWr) && lenCnt != $past(lenCnt))
      |-> (lenCnt == LEN_W'($past(lenCnt) - 1'b1)));

  // R8
  vol_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vol != $past(vol)) |-> ($past(tick.quarter) || $past(lenWr)));

  // R9
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enabled) |-> !lenNz);

endmodule

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int CH_CNT = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqTick_t                tick,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [7:0]              wrData,
  output logic [CH_CNT-1:0]       lenNz,
  output logic [CH_CNT*VOL_W-1:0] volFlat
);

  logic [CH_CNT-1:0] enableReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= '0;
    end else if (wrEn && wrAddr == ADDR_W'(ADDR_ENABLE)) begin
      enableReg <= wrData[CH_CNT-1:0];
    end
  end

  for (genvar g = 0; g < CH_CNT; g++) begin : gCh
    logic ctrlWr;
    logic lenWr;
    assign ctrlWr = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL_BASE + g));
    assign lenWr  = wrEn && (wrAddr == ADDR_W'(ADDR_LEN_BASE + g));

    fseq_chan uChan (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (tick),
      .enabled (enableReg[g]),
      .ctrlWr  (ctrlWr),
      .haltIn  (wrData[5]),
      .rateIn  (wrData[3:0]),
      .lenWr   (lenWr),
      .lenIdx  (wrData[7:3]),
      .lenNz   (lenNz[g]),
      .vol     (volFlat[g*VOL_W +: VOL_W])
    );
  end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import fseq_pkg::*;
#(
  parameter int DIV_INC   = 2,
  parameter int DIV_LIMIT = 14915,
  parameter int CH_CNT    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [7:0]              wrData,
  input  logic                    rdStb,
  input  logic                    sampleBusy,
  input  logic                    sampleIrqSet,
  output logic [7:0]              rdData,
  output logic [CH_CNT-1:0]       lenActive,
  output logic [CH_CNT*VOL_W-1:0] envVol,
  output logic                    irq
);

  seqTick_t tick;
  logic     frameWr;
  logic     frameFlag;
  logic     sampleFlag;

  assign frameWr = wrEn && (wrAddr == ADDR_W'(ADDR_FRAME));

  fseq_ctrl #(
    .DIV_INC   (DIV_INC),
    .DIV_LIMIT (DIV_LIMIT)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameWr      (frameWr),
    .modeIn       (wrData[7]),
    .inhibitIn    (wrData[6]),
    .rdStb        (rdStb),
    .sampleIrqSet (sampleIrqSet),
    .tick         (tick),
    .frameFlag    (frameFlag),
    .sampleFlag   (sampleFlag)
  );

  fseq_datapath #(
    .CH_CNT (CH_CNT)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .lenNz   (lenActive),
    .volFlat (envVol)
  );

  always_comb begin
    rdData              = '0;
    rdData[CH_CNT-1:0]  = lenActive;
    rdData[4]           = sampleBusy;
    rdData[6]           = frameFlag;
    rdData[7]           = sampleFlag;
  end

  assign irq = frameFlag || sampleFlag;

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(sampleIrqSet) || rdData[6]));

endmodule

// File: tb/tb_frame_sequencer.sv
module tb_frame_sequencer;

  localparam int LIM = 15;
  localparam int INC = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        rdStb = 1'b0;
  logic        sampleBusy = 1'b0;
  logic        sampleIrqSet = 1'b0;
  logic [7:0]  rdData;
  logic [3:0]  lenActive;
  logic [15:0] envVol;
  logic        irq;

  int testCnt = 0;
  int failCnt = 0;
  int off = 0;

  // {index, expected length}
  localparam logic [12:0] LEN_VEC [0:7] = '{
    {5'd0, 8'd10}, {5'd1, 8'd254}, {5'd3, 8'd2}, {5'd8, 8'd160},
    {5'd12, 8'd14}, {5'd17, 8'd16}, {5'd24, 8'd192}, {5'd31, 8'd30}
  };

  always #4 clk = ~clk;

  frame_sequencer #(.DIV_INC(INC), .DIV_LIMIT(LIM), .CH_CNT(4)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStb(rdStb), .sampleBusy(sampleBusy), .sampleIrqSet(sampleIrqSet),
    .rdData(rdData), .lenActive(lenActive), .envVol(envVol), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    off++;
    wrEn = 1'b0;
  endtask

  task automatic startFrame(input logic [7:0] d);
    wr(4'd9, d);
    off = 0;
  endtask

  task automatic adv(input int t);
    while (off < t) begin
      @(negedge clk);
      off++;
    end
  endtask

  function automatic int tickOff(input int k);
    return (k * LIM + INC - 1) / INC;
  endfunction

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [3:0] snapLen;
    logic [15:0] snapVol;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 lenActive", lenActive, 4'h0);
    check("R1 envVol", envVol, 16'h0);

    wr(4'd8, 8'h0F);

    // R6 R7 R5 R2 table walk: counter empties on half-frame number L
    for (int i = 0; i < 8; i++) begin
      int lv;
      int d;
      lv = int'(LEN_VEC[i][7:0]);
      startFrame(8'h40);
      wr(4'd4, {LEN_VEC[i][12:8], 3'b000});
      d = tickOff(2 * lv - 1);
      adv(d - 1);
      check("R6 length still active", lenActive[0], 1'b1);
      adv(d);
      check("R7 length empties on half-frame", lenActive[0], 1'b0);
    end

    // R7 halt keeps the counter
    wr(4'd2, 8'h20);
    startFrame(8'h40);
    wr(4'd6, {5'd3, 3'b000});
    adv(60);
    check("R7 halted counter held", lenActive[2], 1'b1);

    // R6 R9 enable gating
    wr(4'd8, 8'h0D);
    wr(4'd5, {5'd1, 3'b000});
    @(negedge clk);
    check("R6 disabled load ignored", lenActive[1], 1'b0);
    wr(4'd8, 8'h0F);
    wr(4'd5, {5'd1, 3'b000});
    check("R6 enabled load", lenActive[1], 1'b1);
    wr(4'd8, 8'h0D);
    @(negedge clk);
    check("R9 disable clears length", lenActive[1], 1'b0);
    wr(4'd8, 8'h0F);

    // R8 divider rate 1
    wr(4'd3, 8'h01);
    startFrame(8'h40);
    wr(4'd7, 8'h00);
    adv(tickOff(2) - 1);
    check("R8 rate1 before expiry", envVol[15:12], 4'd15);
    adv(tickOff(2));
    check("R8 rate1 expiry", envVol[15:12], 4'd14);

    // R8 loop wrap and no-loop stick
    wr(4'd0, 8'h20);
    wr(4'd1, 8'h00);
    startFrame(8'h40);
    wr(4'd4, 8'h00);
    wr(4'd5, 8'h00);
    adv(tickOff(15));
    check("R8 loop reaches zero", envVol[3:0], 4'd0);
    adv(tickOff(16));
    check("R8 loop wraps to 15", envVol[3:0], 4'd15);
    check("R8 no-loop sticks at 0", envVol[7:4], 4'd0);

    // R3 R5 R4 five-step mode
    wr(4'd3, 8'h00);
    startFrame(8'h80);
    wr(4'd7, 8'h00);
    adv(tickOff(4) - 1);
    check("R5 five-step three quarters", envVol[15:12], 4'd12);
    adv(tickOff(4));
    check("R5 step 4 has no quarter", envVol[15:12], 4'd12);
    adv(tickOff(5));
    check("R3 wrap to step 0 quarter", envVol[15:12], 4'd11);
    adv(80);
    check("R4 no irq in five-step", irq, 1'b0);

    // R4 R12 R10 four-step interrupt
    startFrame(8'h00);
    adv(tickOff(4) - 1);
    check("R4 irq before wrap", irq, 1'b0);
    adv(tickOff(4));
    check("R12 irq on wrap", irq, 1'b1);
    rdStb = 1'b1;
    #1;
    check("R10 status frame bit", rdData[6], 1'b1);
    @(negedge clk); off++;
    rdStb = 1'b0;
    check("R10 read clears irq", irq, 1'b0);

    // R11 inhibit clears pending flag
    adv(tickOff(8));
    check("R4 second frame irq", irq, 1'b1);
    startFrame(8'h40);
    check("R11 inhibit clears", irq, 1'b0);
    adv(tickOff(4) + 2);
    check("R4 inhibit blocks irq", irq, 1'b0);

    // R11 R10 sample flag and status layout
    sampleBusy = 1'b1;
    sampleIrqSet = 1'b1;
    @(negedge clk); off++;
    sampleIrqSet = 1'b0;
    check("R12 sample irq", irq, 1'b1);
    check("R11 status sample bit", rdData[7], 1'b1);
    check("R10 status busy bit", rdData[4], 1'b1);
    check("R10 status bit 5", rdData[5], 1'b0);
    check("R10 status length bits", rdData[3:0], lenActive);
    rdStb = 1'b1;
    @(negedge clk); off++;
    rdStb = 1'b0;
    check("R10 read clears sample", rdData[7], 1'b0);

    // R13 unused addresses
    startFrame(8'h40);
    snapLen = lenActive;
    snapVol = envVol;
    wr(4'd10, 8'hFF);
    wr(4'd15, 8'hFF);
    check("R13 length untouched", lenActive, snapLen);
    check("R13 volume untouched", envVol, snapVol);
    check("R13 irq untouched", irq, 1'b0);

    finish();
  end

endmodule